// File: doc/BRIEF.md
# Frame-Delayed ADPCM Bypass Path

This block forms the transparent route between the PCM octet side and the compressed-word side of a four-channel voice transcoder when the transcoder core is bypassed. PCM-to-ADPCM: the top bits of each channel's octet are placed in that channel's compressed word. ADPCM-to-PCM: each channel's word is placed back in the high bits of its octet. Both directions hold the data for a fixed two frames. Channel data is handled as parallel per-frame vectors. A one-cycle frame tick advances the pipelines.

A 3-bit mode code selects the behaviour:
- Code 011 carries words of four bits, or of three bits when the rate input is high.
- Code 100 carries 2-bit words. All four 2-bit words are packed into one of two timeslots, and the select input picks which one.
- Every other code keeps both outputs at zero.

Each change of the effective configuration flushes both pipelines, so a stale word never leaves the block.

Top module: `adpcm_bypass_delay`

## Requirements
- R1: While reset is low and in the first cycle after it, `adpcm_out` and `pcm_out` are all zero.
- R2: With the configuration unchanged, data sampled on frame tick k is driven on the outputs from the clock edge of tick k+1 until the clock edge of tick k+2. The outputs do not change on cycles without a tick.
- R3: In mode 011 with `rate3`=0 (4-bit bypass):
  - PCM-to-ADPCM: channel n's octet bits [8n+7:8n+4] go to `adpcm_out` [4n+3:4n].
  - ADPCM-to-PCM: `adpcm_in` [4n+3:4n] goes to `pcm_out` [8n+7:8n+4], and octet bits [8n+3:8n] are 0.
  - Channel n always maps to channel n.
- R4: In mode 011 with `rate3`=1 (3-bit bypass):
  - PCM-to-ADPCM: octet bits [8n+7:8n+5] go to `adpcm_out` [4n+3:4n+1], and `adpcm_out` bit 4n is 0.
  - ADPCM-to-PCM: `adpcm_in` [4n+3:4n+1] goes to `pcm_out` [8n+7:8n+5], and the other octet bits are 0.
- R5: In mode 100 (2-bit bypass), timeslot s occupies `adpcm_out`/`adpcm_in` bits [8s+7:8s], where s = `sel`.
  - Channel n's word sits at bits [8s+2n+1:8s+2n], and the unselected timeslot is 0.
  - PCM-to-ADPCM: octet bits [8n+7:8n+6] form that word.
  - ADPCM-to-PCM: the word returns in `pcm_out` [8n+7:8n+6], and the other octet bits are 0.
- R6: In mode 011, `sel` has no effect: toggling it neither flushes nor alters the data in flight.
- R7: In every mode code other than 011 and 100, both outputs are zero from the cycle after that code is applied.
- R8: A change of mode code, of `rate3` in mode 011, or of `sel` in mode 100 clears both pipelines. Both outputs read zero from the next cycle until new data has passed two ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle pulse per frame; advances both pipelines |
| mode | input | 3 | Mode code (011 wide bypass, 100 2-bit bypass) |
| sel | input | 1 | Timeslot choice for the 2-bit bypass |
| rate3 | input | 1 | In mode 011, selects 3-bit words instead of 4-bit |
| pcm_in | input | 32 | Channel octets, channel n at bits [8n+7:8n] |
| adpcm_in | input | 16 | Compressed words, channel n at bits [4n+3:4n] |
| adpcm_out | output | 16 | Delayed bypass words toward the ADPCM side |
| pcm_out | output | 32 | Delayed bypass octets toward the PCM side |

## Verification
Both results are due one cycle after the clock edge of the second tick following the sample. The bench drives inputs on falling edges and checks at the falling edge after every tick. It keeps a two-stage model per direction that advances only on ticks, and so checks that the outputs hold between ticks. A configuration change is due to clear the outputs one cycle after it is applied, and the bench checks at that point before issuing any further tick. It sweeps random data through every bypass variant, through both timeslots and through several non-bypass codes.

// File: rtl/adpcm_bypass_delay.sv
module adpcm_bypass_delay #(
  parameter int NCH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_tick,
  input  logic [2:0]         mode,
  input  logic               sel,
  input  logic               rate3,
  input  logic [8*NCH-1:0]   pcm_in,
  input  logic [4*NCH-1:0]   adpcm_in,
  output logic [4*NCH-1:0]   adpcm_out,
  output logic [8*NCH-1:0]   pcm_out
);
  localparam int OW   = 8 * NCH;
  localparam int AW   = 4 * NCH;
  localparam int SLOT = 2 * NCH;
  localparam logic [2:0] MODE_WIDE   = 3'b011;
  localparam logic [2:0] MODE_NARROW = 3'b100;

  logic wide, narrow, byp, flush;
  logic [4:0] key, key_q;
  logic [AW-1:0] enc_fmt, enc_s1, enc_s2;
  logic [OW-1:0] dec_fmt, dec_s1, dec_s2;

  assign wide   = (mode == MODE_WIDE);
  assign narrow = (mode == MODE_NARROW);
  assign byp    = wide | narrow;
  assign key    = {mode, narrow & sel, wide & rate3};
  assign flush  = !byp || (key != key_q);

  always_comb begin
    enc_fmt = '0;
    dec_fmt = '0;
    for (int n = 0; n < NCH; n++) begin
      if (wide && !rate3) begin
        enc_fmt[4*n +: 4]   = pcm_in[8*n+4 +: 4];
        dec_fmt[8*n+4 +: 4] = adpcm_in[4*n +: 4];
      end else if (wide) begin
        enc_fmt[4*n+1 +: 3] = pcm_in[8*n+5 +: 3];
        dec_fmt[8*n+5 +: 3] = adpcm_in[4*n+1 +: 3];
      end else if (narrow) begin
        if (sel) begin
          enc_fmt[SLOT+2*n +: 2] = pcm_in[8*n+6 +: 2];
          dec_fmt[8*n+6 +: 2]    = adpcm_in[SLOT+2*n +: 2];
        end else begin
          enc_fmt[2*n +: 2]   = pcm_in[8*n+6 +: 2];
          dec_fmt[8*n+6 +: 2] = adpcm_in[2*n +: 2];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q  <= '0;
      enc_s1 <= '0;
      enc_s2 <= '0;
      dec_s1 <= '0;
      dec_s2 <= '0;
    end else begin
      key_q <= key;
      if (flush) begin
        enc_s1 <= '0;
        enc_s2 <= '0;
        dec_s1 <= '0;
        dec_s2 <= '0;
      end else if (frame_tick) begin
        enc_s1 <= enc_fmt;
        enc_s2 <= enc_s1;
        dec_s1 <= dec_fmt;
        dec_s2 <= dec_s1;
      end
    end
  end

  assign adpcm_out = enc_s2;
  assign pcm_out   = dec_s2;

  AST_TWO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !flush) |=> (adpcm_out == $past(enc_s1) && pcm_out == $past(dec_s1))); // R2
  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_tick && !flush) |=> ($stable(adpcm_out) && $stable(pcm_out))); // R2
  AST_UNUSED_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (narrow && !flush) |=> (($past(sel) ? adpcm_out[SLOT-1:0] : adpcm_out[AW-1:SLOT]) == '0)); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !byp |=> (adpcm_out == '0 && pcm_out == '0)); // R7
  AST_FLUSH_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (byp && key != key_q) |=> (adpcm_out == '0 && pcm_out == '0)); // R8
endmodule

// File: tb/adpcm_bypass_delay_bench.sv
module adpcm_bypass_delay_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_tick = 1'b0;
  logic [2:0] mode = 3'b000;
  logic sel = 1'b0;
  logic rate3 = 1'b0;
  logic [31:0] pcm_in = '0;
  logic [15:0] adpcm_in = '0;
  logic [15:0] adpcm_out;
  logic [31:0] pcm_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic done = 1'b0;

  logic [15:0] m_enc1 = '0, m_enc2 = '0;
  logic [31:0] m_dec1 = '0, m_dec2 = '0;
  logic [4:0]  m_key = '0;

  always #5 clk = ~clk;

  adpcm_bypass_delay #(.NCH(4)) u_adpcm_bypass_delay (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .mode(mode), .sel(sel),
    .rate3(rate3), .pcm_in(pcm_in), .adpcm_in(adpcm_in),
    .adpcm_out(adpcm_out), .pcm_out(pcm_out));

  function automatic logic [15:0] exp_enc(logic [2:0] md, logic s, logic r3, logic [31:0] p);
    logic [15:0] res = '0;
    for (int n = 0; n < 4; n++) begin
      if (md == 3'b011 && !r3)    res[4*n +: 4]       = p[8*n+4 +: 4];
      else if (md == 3'b011)      res[4*n+1 +: 3]     = p[8*n+5 +: 3];
      else if (md == 3'b100)      res[8*s+2*n +: 2]   = p[8*n+6 +: 2];
    end
    return res;
  endfunction

  function automatic logic [31:0] exp_dec(logic [2:0] md, logic s, logic r3, logic [15:0] a);
    logic [31:0] res = '0;
    for (int n = 0; n < 4; n++) begin
      if (md == 3'b011 && !r3)    res[8*n+4 +: 4] = a[4*n +: 4];
      else if (md == 3'b011)      res[8*n+5 +: 3] = a[4*n+1 +: 3];
      else if (md == 3'b100)      res[8*n+6 +: 2] = a[8*s+2*n +: 2];
    end
    return res;
  endfunction

  task automatic model_edge();
    logic bp;
    logic [4:0] k;
    bp = (mode == 3'b011) || (mode == 3'b100);
    k = {mode, (mode == 3'b100) & sel, (mode == 3'b011) & rate3};
    if (!rst_n) begin
      m_enc1 = '0; m_enc2 = '0; m_dec1 = '0; m_dec2 = '0; m_key = '0;
    end else begin
      if (!bp || k != m_key) begin
        m_enc1 = '0; m_enc2 = '0; m_dec1 = '0; m_dec2 = '0;
      end else if (frame_tick) begin
        m_enc2 = m_enc1; m_dec2 = m_dec1;
        m_enc1 = exp_enc(mode, sel, rate3, pcm_in);
        m_dec1 = exp_dec(mode, sel, rate3, adpcm_in);
      end
      m_key = k;
    end
  endtask

  task automatic check(string tag);
    checks++;
    if (adpcm_out !== m_enc2 || pcm_out !== m_dec2) begin
      errors++;
      $display("FAIL %s: adpcm_out=%h pcm_out=%h expected %h %h", tag, adpcm_out, pcm_out, m_enc2, m_dec2);
    end
  endtask

  task automatic step(logic tk, string tag);
    frame_tick = tk;
    if (tk) begin
      pcm_in = $urandom;
      adpcm_in = 16'($urandom);
    end
    @(posedge clk);
    model_edge();
    @(negedge clk);
    frame_tick = 1'b0;
    check(tag);
  endtask

  task automatic set_cfg(logic [2:0] md, logic s, logic r3, string tag);
    mode = md; sel = s; rate3 = r3;
    step(1'b0, tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(7));
    repeat (3) begin
      @(posedge clk); model_edge();
    end
    @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    step(1'b0, "R1");

    set_cfg(3'b000, 1'b0, 1'b0, "R7");
    for (int i = 0; i < 4; i++) step(1'b1, "R7");

    set_cfg(3'b011, 1'b0, 1'b0, "R8");
    step(1'b1, "R2");
    step(1'b0, "R2");
    step(1'b1, "R2");
    for (int i = 0; i < 16; i++) begin
      step(1'b1, "R3");
      step(1'b0, "R2");
      step(1'b0, "R2");
    end
    sel = 1'b1;
    step(1'b0, "R6");
    for (int i = 0; i < 6; i++) step(1'b1, "R6");
    sel = 1'b0;
    for (int i = 0; i < 4; i++) step(1'b1, "R6");

    set_cfg(3'b011, 1'b0, 1'b1, "R8");
    for (int i = 0; i < 16; i++) step(1'b1, "R4");

    set_cfg(3'b100, 1'b0, 1'b0, "R8");
    for (int i = 0; i < 16; i++) step(1'b1, "R5");
    set_cfg(3'b100, 1'b1, 1'b0, "R8");
    for (int i = 0; i < 16; i++) step(1'b1, "R5");
    set_cfg(3'b100, 1'b0, 1'b0, "R8");
    step(1'b1, "R8");

    for (int md = 0; md < 8; md++) begin
      if (md == 3 || md == 4) continue;
      set_cfg(3'(md), 1'b1, 1'b1, "R7");
      for (int i = 0; i < 3; i++) step(1'b1, "R7");
    end

    set_cfg(3'b011, 1'b1, 1'b0, "R8");
    for (int i = 0; i < 8; i++) step(1'b1, "R3");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule